// File: doc/BRIEF.md
# Complex-Instruction Micro-op Cracker

This block sits behind an instruction decoder and breaks each decoded complex instruction into an ordered run of simple micro-ops. A decoded descriptor enters over a valid/ready handshake. It carries an operation class, three register tags, a function code, two memory-operand flags and a 32-bit immediate, which is either a displacement or a target. The block then emits one micro-op record per cycle on a second valid/ready handshake. Each record holds a kind, source and destination tags, a function code, an immediate and a last flag.

A plain ALU operation, a compare or a branch becomes a single micro-op. An ALU operation that reads memory becomes two micro-ops, and one that writes memory becomes three. A call becomes four micro-ops and a return becomes three. Any value loaded for use by a later micro-op of the same instruction goes into one reserved temporary register, and the later micro-op reads it from there. Address generation (base plus displacement) stays inside the load or store micro-op. A new descriptor is taken only once the final micro-op of the current one is accepted. That acceptance may fall in the same cycle as the new descriptor, so consecutive instructions leave no gap.

Top module: `uop_cracker`

## Requirements
- R1: `inReady` is 1 when no instruction is held, or when the final micro-op is being accepted in that cycle (`outValid` and `outReady` and `outLast` all high). At every other time it is 0.
- R2: The micro-op counts per instruction are: 1 for a plain ALU, compare, branch or unknown class; 2 for ALU with memory source; 3 for ALU with memory destination; 4 for a call; 3 for a return. `outLast` is 1 only on the final micro-op. Kind codes are ALU=0, CMP=1, BR=2, LD=3, ST=4, JMP=5, RDPC=6, TRAP=7. The temporary tag is 31, the stack tag is 4, and any unused tag, function or immediate field is 0.
- R3: Class 0 (ALU) with both memory flags clear gives one record (ALU, srcA, srcB, dst, func, imm).
- R4: Class 0 with `inMemSrc`=1 and `inMemDst`=0 gives (LD, srcB, 0, 31, 0, imm) and then (ALU, srcA, 31, dst, func, 0).
- R5: Class 0 with `inMemDst`=1 gives three records whatever `inMemSrc` is: (LD, srcB, 0, 31, 0, imm), (ALU, 31, srcA, 31, func, 0) and (ST, srcB, 31, 0, 0, imm).
- R6: Class 1 (compare) gives (CMP, srcA, srcB, 0, func, imm). Class 2 (branch) gives (BR, srcA, srcB, 0, func, imm). The memory flags have no effect on either class.
- R7: Class 3 (call) gives, in this order, (RDPC, 0, 0, 31, 0, 0), (ST, 4, 31, 0, 0, -4), (ALU, 4, 0, 4, 0, -4) and (JMP, 0, 0, 0, 0, imm).
- R8: Class 4 (return) gives, in this order, (ALU, 4, 0, 4, 0, +4), (LD, 4, 0, 31, 0, -4) and (JMP, 31, 0, 0, 0, 0).
- R9: Classes 5, 6 and 7 give a single (TRAP, 0, 0, 0, 0, class) record with `outLast`=1.
- R10: While `outValid` is 1 and `outReady` is 0, the micro-op record keeps its value into the next cycle.
- R11: After reset, `outValid` is 0 and `inReady` is 1.
- R12: The first micro-op of an accepted descriptor is on the outputs in the cycle after acceptance, including when that acceptance coincides with the final micro-op of the previous instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Descriptor valid |
| inReady | output | 1 | Descriptor can be taken |
| inClass | input | 3 | Operation class |
| inSrcA | input | 5 | First source tag |
| inSrcB | input | 5 | Second source tag, or address base |
| inDst | input | 5 | Destination tag |
| inFunc | input | 4 | ALU function or branch condition |
| inMemSrc | input | 1 | ALU operand read from memory |
| inMemDst | input | 1 | ALU result written to memory |
| inImm | input | 32 | Immediate, displacement or target |
| outValid | output | 1 | Micro-op valid |
| outReady | input | 1 | Micro-op taken by consumer |
| outKind | output | 3 | Micro-op kind |
| outSrcA | output | 5 | Micro-op first source tag |
| outSrcB | output | 5 | Micro-op second source tag |
| outDst | output | 5 | Micro-op destination tag |
| outFunc | output | 4 | Micro-op function code |
| outImm | output | 32 | Micro-op immediate |
| outLast | output | 1 | Final micro-op of the instruction |

## Verification
A descriptor accepted at one rising edge shows its first micro-op on the outputs right after that edge. Each later micro-op appears one edge after its predecessor is accepted. `inReady` is combinational on `outReady` within the same cycle. The bench drives inputs on the falling edge, waits a short settle delay, and compares the full record, the last flag and `inReady` against a bench model. It repeats this on every falling edge of a stall, so a held record is compared once per stalled cycle. It also compares right after the edge that takes a last micro-op together with a new descriptor, which tests the gap-free hand-off.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int TAG_W  = 5;
  localparam int FUNC_W = 4;
  localparam int IMM_W  = 32;
  localparam int CLS_W  = 3;
  localparam int KIND_W = 3;
  localparam int STEP_W = 2;
  localparam int CNT_W  = STEP_W + 1;

  localparam logic [TAG_W-1:0]  TMP_TAG  = '1;
  localparam logic [FUNC_W-1:0] FUNC_ADD = '0;
  localparam logic [IMM_W-1:0]  STK_DEC  = -IMM_W'(4);
  localparam logic [IMM_W-1:0]  STK_INC  = IMM_W'(4);

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU  = 3'd0,
    CLS_CMP  = 3'd1,
    CLS_BR   = 3'd2,
    CLS_CALL = 3'd3,
    CLS_RET  = 3'd4
  } opClass_e;

  typedef enum logic [KIND_W-1:0] {
    K_ALU  = 3'd0,
    K_CMP  = 3'd1,
    K_BR   = 3'd2,
    K_LD   = 3'd3,
    K_ST   = 3'd4,
    K_JMP  = 3'd5,
    K_RDPC = 3'd6,
    K_TRAP = 3'd7
  } uopKind_e;

  typedef struct packed {
    logic [CLS_W-1:0]  cls;
    logic [TAG_W-1:0]  srcA;
    logic [TAG_W-1:0]  srcB;
    logic [TAG_W-1:0]  dst;
    logic [FUNC_W-1:0] func;
    logic              memSrc;
    logic              memDst;
    logic [IMM_W-1:0]  imm;
  } desc_t;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [TAG_W-1:0]  srcA;
    logic [TAG_W-1:0]  srcB;
    logic [TAG_W-1:0]  dst;
    logic [FUNC_W-1:0] func;
    logic [IMM_W-1:0]  imm;
  } uop_t;

  typedef struct packed {
    logic              load;
    logic [STEP_W-1:0] step;
  } ctrlStrobe_t;
endpackage

// File: rtl/uop_ctrl.sv
module uop_ctrl
  import uop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  input  logic        lastStep,
  output ctrlStrobe_t strobe
);
  logic              busy;
  logic [STEP_W-1:0] step;
  logic              accept;
  logic              fire;

  assign inReady  = !busy || (outReady && lastStep);
  assign accept   = inValid && inReady;
  assign fire     = busy && outReady;
  assign outValid = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      step <= '0;
    end else if (fire && lastStep) begin
      busy <= 1'b0;
      step <= '0;
    end else if (fire) begin
      step <= step + STEP_W'(1);
    end
  end

  always_comb begin
    strobe.load = accept;
    strobe.step = step;
  end
endmodule

// File: rtl/uop_dpath.sv
module uop_dpath
  import uop_pkg::*;
#(
  parameter logic [TAG_W-1:0] SP_TAG = 5'd4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  desc_t       inDesc,
  output uop_t        uop,
  output logic        lastStep
);
  desc_t            held;
  logic [CNT_W-1:0] uopCount;

  always_ff @(posedge clk) begin
    if (!rstN)            held <= '0;
    else if (strobe.load) held <= inDesc;
  end

  always_comb begin
    case (held.cls)
      CLS_ALU:  uopCount = held.memDst ? CNT_W'(3) : (held.memSrc ? CNT_W'(2) : CNT_W'(1));
      CLS_CALL: uopCount = CNT_W'(4);
      CLS_RET:  uopCount = CNT_W'(3);
      default:  uopCount = CNT_W'(1);
    endcase
  end

  assign lastStep = ({1'b0, strobe.step} == (uopCount - CNT_W'(1)));

  function automatic uop_t mk(input uopKind_e k, input logic [TAG_W-1:0] a,
                              input logic [TAG_W-1:0] b, input logic [TAG_W-1:0] d,
                              input logic [FUNC_W-1:0] f, input logic [IMM_W-1:0] i);
    uop_t u;
    u.kind = k; u.srcA = a; u.srcB = b; u.dst = d; u.func = f; u.imm = i;
    return u;
  endfunction

  always_comb begin
    uop = '0;
    case (held.cls)
      CLS_ALU: begin
        if (held.memDst) begin
          case (strobe.step)
            2'd0:    uop = mk(K_LD,  held.srcB, '0, TMP_TAG, '0, held.imm);
            2'd1:    uop = mk(K_ALU, TMP_TAG, held.srcA, TMP_TAG, held.func, '0);
            default: uop = mk(K_ST,  held.srcB, TMP_TAG, '0, '0, held.imm);
          endcase
        end else if (held.memSrc) begin
          if (strobe.step == 2'd0) uop = mk(K_LD,  held.srcB, '0, TMP_TAG, '0, held.imm);
          else                     uop = mk(K_ALU, held.srcA, TMP_TAG, held.dst, held.func, '0);
        end else begin
          uop = mk(K_ALU, held.srcA, held.srcB, held.dst, held.func, held.imm);
        end
      end
      CLS_CMP: uop = mk(K_CMP, held.srcA, held.srcB, '0, held.func, held.imm);
      CLS_BR:  uop = mk(K_BR,  held.srcA, held.srcB, '0, held.func, held.imm);
      CLS_CALL: begin
        case (strobe.step)
          2'd0:    uop = mk(K_RDPC, '0, '0, TMP_TAG, '0, '0);
          2'd1:    uop = mk(K_ST,   SP_TAG, TMP_TAG, '0, '0, STK_DEC);
          2'd2:    uop = mk(K_ALU,  SP_TAG, '0, SP_TAG, FUNC_ADD, STK_DEC);
          default: uop = mk(K_JMP,  '0, '0, '0, '0, held.imm);
        endcase
      end
      CLS_RET: begin
        case (strobe.step)
          2'd0:    uop = mk(K_ALU, SP_TAG, '0, SP_TAG, FUNC_ADD, STK_INC);
          2'd1:    uop = mk(K_LD,  SP_TAG, '0, TMP_TAG, '0, STK_DEC);
          default: uop = mk(K_JMP, TMP_TAG, '0, '0, '0, '0);
        endcase
      end
      default: uop = mk(K_TRAP, '0, '0, '0, '0, IMM_W'(held.cls));
    endcase
  end
endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
  import uop_pkg::*;
#(
  parameter logic [TAG_W-1:0] SP_TAG = 5'd4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CLS_W-1:0]  inClass,
  input  logic [TAG_W-1:0]  inSrcA,
  input  logic [TAG_W-1:0]  inSrcB,
  input  logic [TAG_W-1:0]  inDst,
  input  logic [FUNC_W-1:0] inFunc,
  input  logic              inMemSrc,
  input  logic              inMemDst,
  input  logic [IMM_W-1:0]  inImm,
  output logic              outValid,
  input  logic              outReady,
  output logic [KIND_W-1:0] outKind,
  output logic [TAG_W-1:0]  outSrcA,
  output logic [TAG_W-1:0]  outSrcB,
  output logic [TAG_W-1:0]  outDst,
  output logic [FUNC_W-1:0] outFunc,
  output logic [IMM_W-1:0]  outImm,
  output logic              outLast
);
  desc_t       inDesc;
  ctrlStrobe_t strobe;
  uop_t        curUop;
  logic        lastStep;

  always_comb begin
    inDesc.cls    = inClass;
    inDesc.srcA   = inSrcA;
    inDesc.srcB   = inSrcB;
    inDesc.dst    = inDst;
    inDesc.func   = inFunc;
    inDesc.memSrc = inMemSrc;
    inDesc.memDst = inMemDst;
    inDesc.imm    = inImm;
  end

  uop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .lastStep(lastStep), .strobe(strobe)
  );

  uop_dpath #(.SP_TAG(SP_TAG)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inDesc(inDesc),
    .uop(curUop), .lastStep(lastStep)
  );

  assign outKind = curUop.kind;
  assign outSrcA = curUop.srcA;
  assign outSrcB = curUop.srcB;
  assign outDst  = curUop.dst;
  assign outFunc = curUop.func;
  assign outImm  = curUop.imm;
  assign outLast = lastStep;
endmodule

// File: rtl/uop_cracker_chk.sv
module uop_cracker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [2:0]  outKind,
  input logic [4:0]  outSrcA,
  input logic [4:0]  outSrcB,
  input logic [4:0]  outDst,
  input logic [3:0]  outFunc,
  input logic [31:0] outImm,
  input logic        outLast
);
  // R1: ready only when idle or the final micro-op is leaving
  a_r1_ready_gate: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!outValid || (outReady && outLast)));

  // R2: a non-final micro-op that is taken is followed by another
  a_r2_seq_continues: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outLast) |=> outValid);

  // R7: the PC read opens a call and is never its last step
  a_r7_rdpc_not_last: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 3'd6) |-> !outLast);

  // R9: a trap is always a one-step instruction
  a_r9_trap_last: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 3'd7) |-> outLast);

  // R10: stalled record holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outKind) && $stable(outSrcA)
      && $stable(outSrcB) && $stable(outDst) && $stable(outFunc)
      && $stable(outImm) && $stable(outLast)));

  // R12: acceptance produces output next cycle
  a_r12_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);
endmodule

bind uop_cracker uop_cracker_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outKind(outKind),
  .outSrcA(outSrcA), .outSrcB(outSrcB), .outDst(outDst), .outFunc(outFunc),
  .outImm(outImm), .outLast(outLast)
);

// File: tb/uop_cracker_tb.sv
`timescale 1ns/1ps
module uop_cracker_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [2:0] inClass = '0;
  logic [4:0] inSrcA = '0, inSrcB = '0, inDst = '0;
  logic [3:0] inFunc = '0;
  logic inMemSrc = 1'b0, inMemDst = 1'b0;
  logic [31:0] inImm = '0;
  logic outValid;
  logic outReady = 1'b0;
  logic [2:0] outKind;
  logic [4:0] outSrcA, outSrcB, outDst;
  logic [3:0] outFunc;
  logic [31:0] outImm;
  logic outLast;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uop_cracker u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inClass(inClass), .inSrcA(inSrcA), .inSrcB(inSrcB), .inDst(inDst),
    .inFunc(inFunc), .inMemSrc(inMemSrc), .inMemDst(inMemDst), .inImm(inImm),
    .outValid(outValid), .outReady(outReady), .outKind(outKind),
    .outSrcA(outSrcA), .outSrcB(outSrcB), .outDst(outDst), .outFunc(outFunc),
    .outImm(outImm), .outLast(outLast)
  );

  typedef struct {
    logic [2:0] cls; logic [4:0] a, b, d; logic [3:0] f;
    logic ms, md; logic [31:0] imm;
  } tdesc_t;

  typedef struct {
    logic [2:0] kind; logic [4:0] a, b, d; logic [3:0] f; logic [31:0] imm;
  } texp_t;

  localparam logic [4:0] T = 5'd31;
  localparam logic [4:0] S = 5'd4;
  localparam logic [31:0] M4 = 32'hFFFF_FFFC;

  function automatic int expCount(tdesc_t x);
    case (x.cls)
      3'd0: return x.md ? 3 : (x.ms ? 2 : 1);
      3'd3: return 4;
      3'd4: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic string reqOf(tdesc_t x);
    case (x.cls)
      3'd0: return x.md ? "R5" : (x.ms ? "R4" : "R3");
      3'd1, 3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic texp_t mkE(logic [2:0] k, logic [4:0] a, logic [4:0] b,
                                logic [4:0] d, logic [3:0] f, logic [31:0] i);
    texp_t e;
    e.kind = k; e.a = a; e.b = b; e.d = d; e.f = f; e.imm = i;
    return e;
  endfunction

  function automatic texp_t expUop(tdesc_t x, int j);
    case (x.cls)
      3'd0: begin
        if (x.md) begin
          if (j == 0) return mkE(3, x.b, 0, T, 0, x.imm);
          if (j == 1) return mkE(0, T, x.a, T, x.f, 0);
          return mkE(4, x.b, T, 0, 0, x.imm);
        end
        if (x.ms) begin
          if (j == 0) return mkE(3, x.b, 0, T, 0, x.imm);
          return mkE(0, x.a, T, x.d, x.f, 0);
        end
        return mkE(0, x.a, x.b, x.d, x.f, x.imm);
      end
      3'd1: return mkE(1, x.a, x.b, 0, x.f, x.imm);
      3'd2: return mkE(2, x.a, x.b, 0, x.f, x.imm);
      3'd3: begin
        if (j == 0) return mkE(6, 0, 0, T, 0, 0);
        if (j == 1) return mkE(4, S, T, 0, 0, M4);
        if (j == 2) return mkE(0, S, 0, S, 0, M4);
        return mkE(5, 0, 0, 0, 0, x.imm);
      end
      3'd4: begin
        if (j == 0) return mkE(0, S, 0, S, 0, 32'd4);
        if (j == 1) return mkE(3, S, 0, T, 0, M4);
        return mkE(5, T, 0, 0, 0, 0);
      end
      default: return mkE(7, 0, 0, 0, 0, {29'd0, x.cls});
    endcase
  endfunction

  function automatic tdesc_t getDesc(int n);
    tdesc_t x;
    x.a = 5'($urandom % 31); x.b = 5'($urandom % 31); x.d = 5'($urandom % 31);
    x.f = 4'($urandom); x.imm = $urandom; x.ms = 1'($urandom); x.md = 1'($urandom);
    x.cls = 3'($urandom);
    case (n)
      0: begin x.cls = 0; x.ms = 0; x.md = 0; end
      1: begin x.cls = 0; x.ms = 1; x.md = 0; end
      2: begin x.cls = 0; x.ms = 0; x.md = 1; end
      3: begin x.cls = 0; x.ms = 1; x.md = 1; end
      4: begin x.cls = 1; x.ms = 1; x.md = 1; end
      5: begin x.cls = 2; x.ms = 1; x.md = 0; end
      6: x.cls = 3;
      7: x.cls = 4;
      8: x.cls = 5;
      9: x.cls = 7;
      default: ;
    endcase
    return x;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkUop(tdesc_t x, int j);
    texp_t e;
    bit ok;
    e = expUop(x, j);
    ok = outValid && outKind == e.kind && outSrcA == e.a && outSrcB == e.b &&
         outDst == e.d && outFunc == e.f && outImm == e.imm;
    check(ok, reqOf(x), $sformatf("uop %0d kind/a/b/d/f/imm", j),
          {outKind, outSrcA, outSrcB, outDst, outFunc, outImm},
          {e.kind, e.a, e.b, e.d, e.f, e.imm});
    check(outLast == (j == expCount(x) - 1), "R2", "last flag", 64'(outLast),
          64'(j == expCount(x) - 1));
  endtask

  task automatic driveDesc(tdesc_t x);
    inClass = x.cls; inSrcA = x.a; inSrcB = x.b; inDst = x.d; inFunc = x.f;
    inMemSrc = x.ms; inMemDst = x.md; inImm = x.imm;
    inValid = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    tdesc_t cur, nxt;
    int cnt, holds;
    bit b2b;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; #1;
    // R11 reset state
    check(!outValid, "R11", "outValid after reset", 64'(outValid), 0);
    check(inReady, "R11", "inReady after reset", 64'(inReady), 1);
    cur = getDesc(0);
    driveDesc(cur);
    @(posedge clk); @(negedge clk); inValid = 1'b0;
    for (int n = 0; n < 400; n++) begin
      cnt = expCount(cur);
      b2b = 1'b0;
      for (int j = 0; j < cnt; j++) begin
        holds = (n < 10) ? 1 : int'($urandom % 3);
        for (int h = 0; h < holds; h++) begin
          outReady = 1'b0; #1;
          checkUop(cur, j); // R10 held record compared every stalled cycle
          check(!inReady, "R1", "inReady during stall", 64'(inReady), 0);
          @(posedge clk); @(negedge clk);
        end
        outReady = 1'b1; #1;
        checkUop(cur, j);
        check(inReady == (j == cnt - 1), "R1", "inReady while taking", 64'(inReady),
              64'(j == cnt - 1));
        if (j == cnt - 1) begin
          nxt = getDesc(n + 1);
          if (n >= 10 && $urandom % 2 == 1) begin
            driveDesc(nxt); // R12 hand-off in the same cycle
            b2b = 1'b1;
          end
        end
        @(posedge clk); @(negedge clk);
      end
      if (b2b) begin
        inValid = 1'b0; #1;
        check(outValid, "R12", "valid right after overlapped accept", 64'(outValid), 1);
      end else begin
        outReady = 1'b0; #1;
        check(!outValid, "R2", "idle after final step", 64'(outValid), 0);
        check(inReady, "R1", "inReady when idle", 64'(inReady), 1);
        driveDesc(nxt);
        @(posedge clk); @(negedge clk); inValid = 1'b0;
      end
      cur = nxt;
    end
    finishRun();
  end
endmodule